// File: doc/BRIEF.md
# Looping Descriptor Queue

This block is a small first-in first-out queue for transfer descriptors, held in a dual-port RAM with independent read and write addresses. A host pushes descriptors and a consumer, typically a DMA engine, pops them in the order they were written. As long as the loop control is low, the block is an ordinary queue that drains to empty.

When the loop control is raised while descriptors are waiting, the queue captures the group of entries present at that moment as a chain. From then on each pop still delivers the next entry, but the pop of the last entry in the chain does not empty the queue. Instead the read pointer returns to the first chain entry and the fill count goes back to the chain length. The write pointer is never moved by this rewind.

The consumer therefore sees the same descriptors over and over, which gives ping-pong or multi-buffer cycling with no host work per round. A one-cycle wrap pulse marks every rewind so the host can follow its position in the chain. Lowering the loop control turns the block back into a plain queue, and the entries still held drain out in order.

Top module: `desc_loop_fifo`

## Requirements
- R1: After a synchronous active-low reset, `empty` is 1, `full` is 0 and `wrap` is 0.
- R2: With `loop_en` low, descriptors leave in the order they were pushed, and `pop_data` shows the oldest stored descriptor in the same cycle whenever `empty` is 0.
- R3: `full` is 1 once DEPTH descriptors are held (DEPTH is 8 by default). A push while `full` is 1 is dropped, so a drain returns exactly DEPTH descriptors.
- R4: A pop while `empty` is 1 has no effect. The queue stays empty, and later pushes and pops deliver the correct data.
- R5: In the cycle `loop_en` is first seen high with entries present, the chain is captured as the entries left after any pop taken in that same cycle.
- R6: While looping, the pop of the last chain entry rewinds the read side, so the next `pop_data` is the first chain entry again, and this repeats for any number of rounds.
- R7: `wrap` is high for exactly the one cycle that follows each rewinding pop, and it stays low after every other pop.
- R8: Pushes are ignored whenever `loop_en` is 1. They change neither the stored chain nor the fill count.
- R9: While a chain is looping, `empty` never becomes 1.
- R10: After `loop_en` goes low, the block is a normal queue again. The remaining entries drain in order, and after a rewind the full chain length drains before `empty` rises.
- R11: Raising `loop_en` on an empty queue arms nothing: pops stay ignored and `wrap` stays low.
- R12: A chain of length one rewinds on every pop and keeps delivering the same descriptor.
- R13: With `loop_en` low, a push and a pop in the same cycle on a non-empty queue are both taken, and the fill level is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| push | input | 1 | Write `push_data` into the queue |
| push_data | input | DATA_W | Descriptor to store |
| full | output | 1 | Queue holds DEPTH descriptors |
| pop | input | 1 | Consume the descriptor on `pop_data` |
| pop_data | output | DATA_W | Oldest stored descriptor (valid when not empty) |
| empty | output | 1 | Queue holds no descriptor |
| loop_en | input | 1 | Capture and replay the held descriptors as a chain |
| wrap | output | 1 | One-cycle pulse after each chain rewind |

## Verification
The bench drives an 8-entry chain through several rounds. A design that rewound one entry early or one entry late would show it as the wrong descriptor on `pop_data` at the round boundary, or as a `wrap` pulse on the wrong pop. A chain armed in the same cycle as a pop checks that the chain start comes from the post-pop pointer; getting this wrong would replay an entry the consumer had already taken. A push offered during looping, followed by disarming and draining, shows whether a stray entry slipped into the RAM or the count. It also shows whether the restored count was right: a count that was not restored would empty the queue too early. A one-entry chain and arming with an empty queue cover the degenerate cases, where a design that did not special-case them would pulse `wrap` wrongly or report an empty queue as non-empty.

// File: rtl/desc_loop_pkg.sv
// Shared types for the looping descriptor queue.
// Assumes nothing beyond being compiled before the modules that import it.
package desc_loop_pkg;

    // Accepted queue operation in one cycle: {push taken, pop taken}.
    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_POP  = 2'b01,
        OP_PUSH = 2'b10,
        OP_BOTH = 2'b11
    } fifo_op_e;

endpackage

// File: rtl/desc_dpram.sv
// Descriptor storage: a simple dual-port RAM with one synchronous write port
// and one asynchronous read port, each with its own address.
// Assumes the caller never writes a location it is reading in a way that
// needs write-through; the read port returns the stored word.
module desc_dpram #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Write port: store one descriptor per enabled cycle.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Read port: present the addressed descriptor combinationally.
    assign rdata = mem[raddr];

endmodule

// File: rtl/desc_ptr_unit.sv
// Read pointer, write pointer and fill count of the queue.
// Offers the plain next values (ignoring any rewind) to the chain control,
// then applies a rewind by loading the captured chain start and length.
// Assumes push_ok and pop_ok are already qualified against full and empty.
module desc_ptr_unit
    import desc_loop_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_ok,
    input  logic              pop_ok,
    input  logic              rewind,
    input  logic [ADDR_W-1:0] chain_start,
    input  logic [CNT_W-1:0]  chain_len,
    output logic [ADDR_W-1:0] rd_ptr,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic [CNT_W-1:0]  count,
    output logic [ADDR_W-1:0] rd_step,
    output logic [CNT_W-1:0]  cnt_step
);

    localparam bit PTR_POW2 = (DEPTH == (1 << ADDR_W));

    logic [ADDR_W-1:0] rd_inc;
    logic [ADDR_W-1:0] wr_inc;
    fifo_op_e          op;

    // Pointer increment: natural rollover for power-of-two depths,
    // explicit compare-and-clear otherwise.
    generate
        if (PTR_POW2) begin : g_pow2_wrap
            assign rd_inc = rd_ptr + ADDR_W'(1);
            assign wr_inc = wr_ptr + ADDR_W'(1);
        end else begin : g_cmp_wrap
            assign rd_inc = (rd_ptr == ADDR_W'(DEPTH - 1)) ? '0 : rd_ptr + ADDR_W'(1);
            assign wr_inc = (wr_ptr == ADDR_W'(DEPTH - 1)) ? '0 : wr_ptr + ADDR_W'(1);
        end
    endgenerate

    assign op = fifo_op_e'({push_ok, pop_ok});

    // Plain next state of count and read pointer, before any rewind.
    always_comb begin
        unique case (op)
            OP_PUSH: cnt_step = count + CNT_W'(1);
            OP_POP:  cnt_step = count - CNT_W'(1);
            default: cnt_step = count;
        endcase
        rd_step = pop_ok ? rd_inc : rd_ptr;
    end

    // Register update: a rewind overrides the read side only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= wr_inc;
            end
            if (rewind) begin
                rd_ptr <= chain_start;
                count  <= chain_len;
            end else begin
                rd_ptr <= rd_step;
                count  <= cnt_step;
            end
        end
    end

endmodule

// File: rtl/desc_chain_ctrl.sv
// Chain control: arms on loop_en, captures the chain start and length from
// the post-pop queue state, detects the pop of the final chain entry and
// produces the registered wrap pulse.
// Assumes pushes are blocked by the caller while loop_en is high, so the
// fill count only falls during looping and reaches one at the last entry.
module desc_chain_ctrl #(
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loop_en,
    input  logic              pop_ok,
    input  logic [CNT_W-1:0]  count,
    input  logic [ADDR_W-1:0] rd_step,
    input  logic [CNT_W-1:0]  cnt_step,
    output logic              armed,
    output logic              rewind,
    output logic [ADDR_W-1:0] chain_start,
    output logic [CNT_W-1:0]  chain_len,
    output logic              wrap
);

    logic loop_act;
    logic arm_now;

    assign loop_act = armed & loop_en;
    assign arm_now  = loop_en & ~armed & (cnt_step != '0);
    assign rewind   = loop_act & pop_ok & (count == CNT_W'(1));

    // Arming state and chain capture; disarm as soon as loop_en is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed       <= 1'b0;
            chain_start <= '0;
            chain_len   <= '0;
        end else if (!loop_en) begin
            armed <= 1'b0;
        end else if (arm_now) begin
            armed       <= 1'b1;
            chain_start <= rd_step;
            chain_len   <= cnt_step;
        end
    end

    // Wrap pulse: one cycle after every rewinding pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wrap <= 1'b0;
        end else begin
            wrap <= rewind;
        end
    end

endmodule

// File: rtl/desc_loop_fifo.sv
// Looping descriptor queue top level.
// Qualifies push and pop against the queue state, blocks pushes while loop
// control is high, and ties together storage, pointers and chain control.
// Assumes DEPTH >= 2 and a single clock domain for host and consumer.
module desc_loop_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    output logic              full,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic              empty,
    input  logic              loop_en,
    output logic              wrap
);

    localparam int ADDR_W = $clog2(DEPTH);
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic              push_ok;
    logic              pop_ok;
    logic              rewind;
    logic              looping;
    logic [ADDR_W-1:0] rd_ptr;
    logic [ADDR_W-1:0] wr_ptr;
    logic [ADDR_W-1:0] rd_step;
    logic [ADDR_W-1:0] chain_start;
    logic [CNT_W-1:0]  count;
    logic [CNT_W-1:0]  cnt_step;
    logic [CNT_W-1:0]  chain_len;

    // Status flags from the fill count.
    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));

    // Request qualification: no push while looping control is high.
    assign push_ok = push & ~loop_en & ~full;
    assign pop_ok  = pop & ~empty;

    desc_dpram #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_ram (
        .clk   (clk),
        .we    (push_ok),
        .waddr (wr_ptr),
        .wdata (push_data),
        .raddr (rd_ptr),
        .rdata (pop_data)
    );

    desc_ptr_unit #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_ok     (push_ok),
        .pop_ok      (pop_ok),
        .rewind      (rewind),
        .chain_start (chain_start),
        .chain_len   (chain_len),
        .rd_ptr      (rd_ptr),
        .wr_ptr      (wr_ptr),
        .count       (count),
        .rd_step     (rd_step),
        .cnt_step    (cnt_step)
    );

    desc_chain_ctrl #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .loop_en     (loop_en),
        .pop_ok      (pop_ok),
        .count       (count),
        .rd_step     (rd_step),
        .cnt_step    (cnt_step),
        .armed       (looping),
        .rewind      (rewind),
        .chain_start (chain_start),
        .chain_len   (chain_len),
        .wrap        (wrap)
    );

endmodule

// File: rtl/desc_loop_fifo_chk.sv
// Assertion checker for the looping descriptor queue, bound to the top.
// Observes ports plus the internal armed flag of the chain control.
module desc_loop_fifo_chk (
    input logic clk,
    input logic rst_n,
    input logic push,
    input logic pop,
    input logic loop_en,
    input logic empty,
    input logic full,
    input logic wrap,
    input logic looping
);

    // R1: reset leaves an empty, non-full queue with no wrap pulse.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (empty && !full && !wrap));

    // R3: a push into a full queue with no pop leaves it full.
    a_r3_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);

    // R3: the queue is never full and empty at once.
    a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R4: a pop on an empty queue without a push keeps it empty.
    a_r4_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);

    // R7: a wrap pulse is only ever the result of a pop one cycle earlier.
    a_r7_wrap_follows_pop: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |-> ($past(pop) && $past(loop_en)));

    // R8: with loop control high and no pop, pushes change no flag.
    a_r8_push_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_en && !pop) |=> ($stable(empty) && $stable(full)));

    // R9: an armed, enabled chain never reports empty.
    a_r9_loop_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (looping && loop_en) |-> !empty);

endmodule

bind desc_loop_fifo desc_loop_fifo_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (push),
    .pop     (pop),
    .loop_en (loop_en),
    .empty   (empty),
    .full    (full),
    .wrap    (wrap),
    .looping (looping)
);

// File: tb/sim_desc_loop_fifo.sv
module sim_desc_loop_fifo;

    localparam int CLK_P  = 10;
    localparam int DATA_W = 32;
    localparam int DEPTH  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              push = 1'b0;
    logic [DATA_W-1:0] push_data = '0;
    logic              full;
    logic              pop = 1'b0;
    logic [DATA_W-1:0] pop_data;
    logic              empty;
    logic              loop_en = 1'b0;
    logic              wrap;

    int checks = 0;
    int errors = 0;

    always #(CLK_P / 2) clk = ~clk;

    desc_loop_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .full(full), .pop(pop), .pop_data(pop_data), .empty(empty),
        .loop_en(loop_en), .wrap(wrap)
    );

    task automatic chk(input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // All drives and samples happen at falling edges.
    task automatic push_one(input logic [DATA_W-1:0] d);
        push = 1'b1; push_data = d;
        @(negedge clk);
        push = 1'b0;
    endtask

    task automatic pop_one(input string tag, input logic [DATA_W-1:0] exp,
                           input logic exp_wrap);
        chk({tag, " not empty"}, empty, 1'b0);
        chk({tag, " data"}, pop_data, exp);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        chk({tag, " wrap"}, wrap, exp_wrap);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 empty", empty, 1'b1);
        chk("R1 full", full, 1'b0);
        chk("R1 wrap", wrap, 1'b0);
    endtask

    task automatic t_order;
        push_one(32'hA1); push_one(32'hA2); push_one(32'hA3);
        pop_one("R2 first", 32'hA1, 1'b0);
        pop_one("R2 second", 32'hA2, 1'b0);
        pop_one("R2 third", 32'hA3, 1'b0);
        chk("R2 empty after drain", empty, 1'b1);
    endtask

    task automatic t_full;
        for (int i = 0; i < DEPTH; i++) push_one(32'hB0 + i);
        chk("R3 full at depth", full, 1'b1);
        push_one(32'hBEEF);
        chk("R3 still full", full, 1'b1);
        for (int i = 0; i < DEPTH; i++) pop_one("R3 drain", 32'hB0 + i, 1'b0);
        chk("R3 extra push dropped", empty, 1'b1);
    endtask

    task automatic t_empty_pop;
        pop = 1'b1; idle(2); pop = 1'b0;
        chk("R4 empty after pop", empty, 1'b1);
        chk("R4 no wrap", wrap, 1'b0);
        push_one(32'hC1);
        pop_one("R4 later data", 32'hC1, 1'b0);
        chk("R4 empty again", empty, 1'b1);
    endtask

    task automatic t_simul;
        push_one(32'hD1);
        push = 1'b1; push_data = 32'hD2;
        chk("R13 head", pop_data, 32'hD1);
        pop = 1'b1;
        @(negedge clk);
        push = 1'b0; pop = 1'b0;
        pop_one("R13 pushed entry", 32'hD2, 1'b0);
        chk("R13 level kept", empty, 1'b1);
    endtask

    task automatic t_loop8;
        for (int i = 0; i < DEPTH; i++) push_one(32'hE0 + i);
        loop_en = 1'b1;
        idle(1);
        for (int r = 0; r < 3; r++)
            for (int i = 0; i < DEPTH; i++)
                pop_one("R6 R7 R9 loop8", 32'hE0 + i, i == DEPTH - 1);
        idle(1);
        chk("R7 single pulse", wrap, 1'b0);
        chk("R9 not empty", empty, 1'b0);
        loop_en = 1'b0;
        idle(1);
        for (int i = 0; i < DEPTH; i++) pop_one("R10 drain8", 32'hE0 + i, 1'b0);
        chk("R10 empty after chain", empty, 1'b1);
    endtask

    task automatic t_push_blocked;
        push_one(32'hF1); push_one(32'hF2); push_one(32'hF3);
        loop_en = 1'b1;
        idle(1);
        push_one(32'hFFFF);
        pop_one("R8 seq", 32'hF1, 1'b0);
        push_one(32'hEEEE);
        pop_one("R8 seq", 32'hF2, 1'b0);
        pop_one("R8 seq", 32'hF3, 1'b1);
        pop_one("R8 after wrap", 32'hF1, 1'b0);
        loop_en = 1'b0;
        idle(1);
        pop_one("R10 mid drain", 32'hF2, 1'b0);
        pop_one("R10 mid drain", 32'hF3, 1'b0);
        chk("R8 R10 no stray entry", empty, 1'b1);
    endtask

    task automatic t_arm_with_pop;
        push_one(32'h11); push_one(32'h12); push_one(32'h13); push_one(32'h14);
        loop_en = 1'b1; pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        pop_one("R5 chain", 32'h12, 1'b0);
        pop_one("R5 chain", 32'h13, 1'b0);
        pop_one("R5 chain end", 32'h14, 1'b1);
        pop_one("R5 restart", 32'h12, 1'b0);
        loop_en = 1'b0;
        idle(1);
        pop_one("R5 drain", 32'h13, 1'b0);
        pop_one("R5 drain", 32'h14, 1'b0);
        chk("R5 empty", empty, 1'b1);
    endtask

    task automatic t_len1;
        push_one(32'h77);
        loop_en = 1'b1;
        idle(1);
        for (int i = 0; i < 3; i++) pop_one("R12 single", 32'h77, 1'b1);
        loop_en = 1'b0;
        idle(1);
        pop_one("R12 drain", 32'h77, 1'b0);
        chk("R12 empty", empty, 1'b1);
    endtask

    task automatic t_empty_arm;
        loop_en = 1'b1;
        idle(1);
        pop = 1'b1; idle(3); pop = 1'b0;
        chk("R11 empty", empty, 1'b1);
        chk("R11 no wrap", wrap, 1'b0);
        loop_en = 1'b0;
        idle(1);
        push_one(32'h99);
        pop_one("R11 normal after", 32'h99, 1'b0);
        chk("R11 empty end", empty, 1'b1);
    endtask

    bit done = 1'b0;

    initial begin
        idle(3);
        t_reset();
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_order();
        t_full();
        t_empty_pop();
        t_simul();
        t_loop8();
        t_push_blocked();
        t_arm_with_pop();
        t_len1();
        t_empty_arm();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule